// File: doc/BRIEF.md
# Serial Digital Video Bit Encoder

This block turns 10-bit parallel video words into a single serial bit stream running at ten times the word rate, suited to a standard-definition serial digital link. A synchronous bit enable, `bit_en`, marks every serial bit period on the fast clock. On the enable that follows the last bit of the previous word, a new word is taken from `pword`. The `word_load` output flags that moment, so the source can present the next word. Words follow one another with no idle bits between them.

Before a word is shifted out, it is conditioned for timing-reference sync words. When its eight upper bits are all zero, its two low bits are cleared. When its eight upper bits are all one, its two low bits are set. This lets an 8-bit source produce valid 10-bit sync codes. `sync_off` turns this conditioning off for data that does not follow the sync convention.

Each serialized bit goes through a self-synchronizing scrambler built on x^9 + x^4 + 1, then through an x + 1 NRZI stage. `raw_sel` chooses between the coded stream and the plain serialized bits. The serial output is held low whenever `lock_in` is low. `lock_out` reports the lock state.

Top module: `sdi_serial_encoder`

## Requirements
- R1: In reset, and after reset until the first bit of the first word has been emitted, `sdo` is 0 and `lock_out` is 0 while in reset.
- R2: When `sync_off` is 0 and `pword[9:2]` is all zeros, the loaded word has bits 1 and 0 forced to 0 (for example, 10'h002 is sent as 10'h000).
- R3: When `sync_off` is 0 and `pword[9:2]` is all ones, the loaded word has bits 1 and 0 forced to 1 (for example, 10'h3FD is sent as 10'h3FF).
- R4: When `sync_off` is 1, and for any word whose upper eight bits are mixed, the word is sent unchanged.
- R5: `word_load` is high only in a cycle with `bit_en` high, and it is high on exactly every tenth enable. The word sampled in that cycle is sent LSB first, one bit per enable, with bit 0 leaving on the load enable itself.
- R6: With `raw_sel` = 1 at an enable, the registered output after that edge equals the serialized bit of that enable.
- R7: With `raw_sel` = 0 at an enable, the scrambled bit is s = b XOR h9 XOR h4. Here b is the serialized bit, and h9 and h4 are the scrambled bits from nine and four enables earlier (0 after reset). The registered output after that edge equals s XOR the previous NRZI output.
- R8: `sdo` is 0 in any cycle where `lock_in` is 0, and the encoder keeps advancing meanwhile. `lock_out` equals `lock_in` delayed by one clock.
- R9: Without `bit_en`, the serializer, scrambler, NRZI and output registers hold their values.
- R10: The scrambler and NRZI state advance on every enable in raw mode too, so coded output after a raw stretch continues from that advanced history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | One pulse per serial bit period |
| pword | input | 10 | Parallel video word, sampled when `word_load` is high |
| sync_off | input | 1 | 1 disables the sync-word LSB forcing |
| raw_sel | input | 1 | 1 sends plain serialized bits, 0 sends scrambled NRZI bits |
| lock_in | input | 1 | Clock-lock indication, 1 when locked |
| word_load | output | 1 | High in the cycle `pword` is taken |
| sdo | output | 1 | Serial data out, gated by lock |
| lock_out | output | 1 | Registered lock status |

## Verification
The lock gate and the word loader can act in the same cycle. The bench provokes this by dropping `lock_in` across a load enable, both in a directed stretch and at random during long runs. It judges the result by two checks: `sdo` must stay at 0 for every unlocked cycle, and once lock returns the bits must match a bench model that kept advancing through the outage. A second overlap is the mode switch. Changing `raw_sel` at random enables, including the load enable, checks that the scrambler history carried across raw stretches still predicts the coded bits.

// File: rtl/sdienc_pkg.sv
package sdienc_pkg;

  localparam int unsigned VIDEO_W  = 10;
  localparam int unsigned SCR_LEN  = 9;
  localparam int unsigned SCR_TAP  = 4;

  typedef enum logic {
    OUT_CODED = 1'b0,
    OUT_RAW   = 1'b1
  } out_mode_e;

endpackage

// File: rtl/sdienc_trs_cond.sv
module sdienc_trs_cond #(
  parameter int unsigned W = 10
) (
  input  logic [W-1:0] din,
  input  logic         bypass,
  output logic [W-1:0] dout
);
  localparam int unsigned UPPER_W = W - 2;

  logic [UPPER_W-1:0] upper;
  logic               upper_zero;
  logic               upper_ones;

  always_comb begin
    upper      = din[W-1:2];
    upper_zero = ~|upper;
    upper_ones = &upper;
    dout       = din;
    if (!bypass) begin
      if (upper_zero) begin
        dout[1:0] = 2'b00;
      end else if (upper_ones) begin
        dout[1:0] = 2'b11;
      end
    end
  end
endmodule

// File: rtl/sdienc_serializer.sv
module sdienc_serializer #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] word_in,
  output logic         load_slot,
  output logic         cur_bit
);
  localparam int unsigned CW   = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] pos_q, pos_d;
  logic [W-1:0]  hold_q, hold_d;

  always_comb begin
    load_slot = (pos_q == '0);
    cur_bit   = load_slot ? word_in[0] : hold_q[pos_q];
    pos_d     = pos_q;
    hold_d    = hold_q;
    if (step) begin
      if (load_slot) begin
        hold_d = word_in;
      end
      pos_d = (pos_q == LAST) ? '0 : pos_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      hold_q <= '0;
    end else begin
      pos_q  <= pos_d;
      hold_q <= hold_d;
    end
  end
endmodule

// File: rtl/sdienc_scrambler.sv
module sdienc_scrambler #(
  parameter int unsigned LEN = 9,
  parameter int unsigned TAP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic din,
  output logic scr_bit,
  output logic nrzi_q,
  output logic nrzi_next
);
  logic [LEN-1:0] hist_q, hist_d;
  logic           nrzi_d;

  always_comb begin
    scr_bit   = din ^ hist_q[LEN-1] ^ hist_q[TAP-1];
    nrzi_next = nrzi_q ^ scr_bit;
    hist_d    = hist_q;
    nrzi_d    = nrzi_q;
    if (step) begin
      hist_d = {hist_q[LEN-2:0], scr_bit};
      nrzi_d = nrzi_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      nrzi_q <= 1'b0;
    end else begin
      hist_q <= hist_d;
      nrzi_q <= nrzi_d;
    end
  end
endmodule

// File: rtl/sdi_serial_encoder.sv
module sdi_serial_encoder
  import sdienc_pkg::*;
#(
  parameter int unsigned W   = VIDEO_W,
  parameter int unsigned LEN = SCR_LEN,
  parameter int unsigned TAP = SCR_TAP
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_en,
  input  logic [W-1:0] pword,
  input  logic         sync_off,
  input  logic         raw_sel,
  input  logic         lock_in,
  output logic         word_load,
  output logic         sdo,
  output logic         lock_out
);
  logic [1:0]   rst_pipe;
  logic         rst_sync_n;
  logic [W-1:0] cond_word;
  logic         load_slot;
  logic         cur_bit;
  logic         scr_bit;
  logic         nrzi_q;
  logic         nrzi_next;
  logic         sdo_q, sdo_d;
  logic         lock_q;
  out_mode_e    mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  sdienc_trs_cond #(.W(W)) u_cond (
    .din    (pword),
    .bypass (sync_off),
    .dout   (cond_word)
  );

  sdienc_serializer #(.W(W)) u_ser (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .step      (bit_en),
    .word_in   (cond_word),
    .load_slot (load_slot),
    .cur_bit   (cur_bit)
  );

  sdienc_scrambler #(.LEN(LEN), .TAP(TAP)) u_scr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .step      (bit_en),
    .din       (cur_bit),
    .scr_bit   (scr_bit),
    .nrzi_q    (nrzi_q),
    .nrzi_next (nrzi_next)
  );

  always_comb begin
    mode  = out_mode_e'(raw_sel);
    sdo_d = sdo_q;
    if (bit_en) begin
      sdo_d = (mode == OUT_RAW) ? cur_bit : nrzi_next;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sdo_q  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      sdo_q  <= sdo_d;
      lock_q <= lock_in;
    end
  end

  assign word_load = bit_en & load_slot;
  assign sdo       = sdo_q & lock_in;
  assign lock_out  = lock_q;
endmodule

// File: rtl/sdienc_checker.sv
module sdienc_checker #(
  parameter int unsigned W = 10
) (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic word_load,
  input logic raw_sel,
  input logic lock_in,
  input logic sdo,
  input logic sdo_q,
  input logic cur_bit,
  input logic scr_bit,
  input logic nrzi_q
);
  logic [7:0] en_since_load;
  logic       seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_since_load <= '0;
      seen          <= 1'b0;
    end else if (bit_en) begin
      seen          <= seen | word_load;
      en_since_load <= word_load ? 8'd0 : en_since_load + 8'd1;
    end
  end

  a_r8_lock_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_in |-> !sdo);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(sdo_q));

  a_r5_load_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
    word_load |-> bit_en);

  a_r5_period: assert property (@(posedge clk) disable iff (!rst_n)
    (word_load && seen) |-> (en_since_load == 8'(W - 1)));

  a_r5_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !word_load && seen) |-> (en_since_load < 8'(W - 1)));

  a_r1_first_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !seen) |-> word_load);

  a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> !sdo_q);

  a_r6_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && raw_sel) |=> (sdo_q == $past(cur_bit)));

  a_r7_nrzi: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !raw_sel) |=> (sdo_q == ($past(nrzi_q) ^ $past(scr_bit))));
endmodule

bind sdi_serial_encoder sdienc_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bit_en    (bit_en),
  .word_load (word_load),
  .raw_sel   (raw_sel),
  .lock_in   (lock_in),
  .sdo       (sdo),
  .sdo_q     (sdo_q),
  .cur_bit   (cur_bit),
  .scr_bit   (scr_bit),
  .nrzi_q    (nrzi_q)
);

// File: tb/sdi_serial_encoder_test.sv
module sdi_serial_encoder_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_en;
  logic [9:0] pword;
  logic       sync_off;
  logic       raw_sel;
  logic       lock_in;
  logic       word_load;
  logic       sdo;
  logic       lock_out;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  int       m_cnt;
  bit [9:0] m_word;
  bit [8:0] m_hist;
  bit       m_nrzi;
  bit       m_q;
  bit       m_lockq;
  bit       m_started;
  int       m_after_raw;
  string    m_tag;
  logic     last_sdo;

  always #2.5 clk = ~clk;

  sdi_serial_encoder uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .pword     (pword),
    .sync_off  (sync_off),
    .raw_sel   (raw_sel),
    .lock_in   (lock_in),
    .word_load (word_load),
    .sdo       (sdo),
    .lock_out  (lock_out)
  );

  function automatic bit [9:0] cond_exp(input bit [9:0] w, input bit off);
    bit [9:0] r = w;
    if (!off && w[9:2] == 8'h00) r[1:0] = 2'b00;
    else if (!off && w[9:2] == 8'hFF) r[1:0] = 2'b11;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit en, input bit [9:0] w, input bit sd,
                     input bit raw, input bit lk);
    bit b;
    bit s;
    bit exp_load;
    string t;
    @(negedge clk);
    bit_en = en; pword = w; sync_off = sd; raw_sel = raw; lock_in = lk;
    #1;
    last_sdo = sdo;
    exp_load = en && (m_cnt == 0);
    chk(word_load === exp_load, "R5", int'(word_load), int'(exp_load));
    if (!lk)             t = "R8";
    else if (!m_started) t = "R1";
    else                 t = m_tag;
    chk(sdo === (m_q & lk), t, int'(sdo), int'(m_q & lk));
    chk(lock_out === m_lockq, "R8", int'(lock_out), int'(m_lockq));
    m_lockq = lk;
    if (en) begin
      if (m_cnt == 0) begin
        m_word    = cond_exp(w, sd);
        m_started = 1'b1;
      end
      b      = m_word[m_cnt];
      s      = b ^ m_hist[8] ^ m_hist[3];
      m_hist = {m_hist[7:0], s};
      m_nrzi = m_nrzi ^ s;
      m_q    = raw ? b : m_nrzi;
      m_cnt  = (m_cnt == 9) ? 0 : m_cnt + 1;
      if (raw) begin
        m_tag = "R6"; m_after_raw = 20;
      end else if (m_after_raw > 0) begin
        m_tag = "R10"; m_after_raw--;
      end else begin
        m_tag = "R7";
      end
    end else begin
      m_tag = "R9";
    end
  endtask

  task automatic send_raw(input bit [9:0] w, input bit sd, input bit [9:0] exp,
                          input string req);
    bit [9:0] rx = '0;
    while (m_cnt != 0) cyc(1'b1, 10'h155, 1'b0, 1'b1, 1'b1);
    for (int k = 0; k <= 10; k++) begin
      cyc(k < 10, w, sd, 1'b1, 1'b1);
      if (k > 0) rx[k-1] = last_sdo;
    end
    chk(rx == exp, req, int'(rx), int'(exp));
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5D1_2E07));
    m_cnt = 0; m_word = '0; m_hist = '0; m_nrzi = 1'b0; m_q = 1'b0;
    m_lockq = 1'b1; m_started = 1'b0; m_after_raw = 0; m_tag = "R1";
    rst_n = 1'b0; bit_en = 1'b0; pword = '0; sync_off = 1'b0;
    raw_sel = 1'b0; lock_in = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(sdo === 1'b0, "R1", int'(sdo), 0);
    chk(lock_out === 1'b0, "R1", int'(lock_out), 0);
    chk(word_load === 1'b0, "R1", int'(word_load), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: idle after reset, output still low
    for (int i = 0; i < 4; i++) cyc(1'b0, 10'h3FF, 1'b0, 1'b0, 1'b1);

    // R2 R3 R4: conditioning seen on the raw output, LSB first (R5)
    send_raw(10'h002, 1'b0, 10'h000, "R2");
    send_raw(10'h001, 1'b0, 10'h000, "R2");
    send_raw(10'h3FD, 1'b0, 10'h3FF, "R3");
    send_raw(10'h3FC, 1'b0, 10'h3FF, "R3");
    send_raw(10'h3FE, 1'b1, 10'h3FE, "R4");
    send_raw(10'h003, 1'b1, 10'h003, "R4");
    send_raw(10'h2B6, 1'b0, 10'h2B6, "R4");

    // R8: lock dropped across a load enable in coded mode
    while (m_cnt != 7) cyc(1'b1, 10'h0F0, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 8; i++) cyc(1'b1, 10'h10F, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 30; i++) cyc(1'b1, 10'h200, 1'b0, 1'b0, 1'b1);

    // R9: long stall with no enables
    for (int i = 0; i < 12; i++) cyc(1'b0, 10'h3FF, 1'b1, 1'b0, 1'b1);

    // Random mix: enables, words, modes and lock outages
    begin
      bit raw_m = 1'b0;
      bit lk_m  = 1'b1;
      for (int i = 0; i < 20000; i++) begin
        bit [9:0] w;
        int sel = $urandom % 8;
        if (sel == 0)      w = {8'h00, 2'($urandom)};
        else if (sel == 1) w = {8'hFF, 2'($urandom)};
        else               w = 10'($urandom);
        if ($urandom % 200 == 0) raw_m = ~raw_m;
        if ($urandom % 150 == 0) lk_m = ~lk_m;
        cyc(($urandom % 3) != 0, w, ($urandom % 8) == 0, raw_m, lk_m);
      end
    end
    for (int i = 0; i < 40; i++) cyc(1'b1, 10'($urandom), 1'b0, 1'b0, 1'b1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule